// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

This block is a register-mapped watchdog that gives software two chances before the system is reset. Two enable bits must both be set before the watchdog runs, and they live in two different registers. While it runs, an interval counter counts 2^N clock cycles over and over. The first time the interval ends, the block sets a state flag and raises an interrupt. If software has not restarted the watchdog when the interval ends a second time, the block sets a sticky reset-status flag and drives a one-cycle reset pulse. The effective timeout is therefore two intervals.

Software restarts the watchdog by writing a one to the state flag, which also sets the interval counter back to zero. The same write-one-to-clear scheme removes the reset-status flag. That flag keeps its value across the reset pulse, so boot code can read why the system went down. A separate counter runs all the time and can be read as a timebase, which lets software confirm that the clock is alive.

An optional build option makes the first enable bit sticky: after it is set, only a hardware reset clears it. The register bus is a plain 32-bit write strobe with a byte address. Reads are decoded combinationally from the address.

Top module: `dsw_top`

## Requirements
- R1: After reset every register reads as zero, the interrupt output is low and the reset output is low.
- R2: Offset 0x0 is control/status 0, with bit 3 = reset status, bit 2 = expiry state, bit 1 = primary enable and bit 0 = a read-only copy of the secondary enable. Offset 0x4 is control/status 1, where bit 0 is the secondary enable (write 1 sets it, write 0 clears it, reads back the same). Offset 0x8 is the timebase. All other bits read as zero.
- R3: The interval counter advances only while both enables are 1. Whenever either enable is 0, the counter is held at zero and no expiry can occur.
- R4: After 2^N consecutive running cycles without a restart, the state bit is set and the interrupt output (which equals the state bit) goes high. The reset output stays low.
- R5: If the interval ends again while the state bit is still set, the reset-status bit is set and the reset output is high for exactly one cycle. It rises 2·2^N cycles after the last restart.
- R6: A write of 1 to bit 2 at offset 0x0 clears the state bit and sets the interval counter to zero. If it lands in the same cycle as an expiry, the restart wins.
- R7: A write of 1 to bit 3 at offset 0x0 clears the reset-status bit. Writing 0 to bits 2 or 3 leaves them unchanged. A new expiry that sets the reset-status bit in the same cycle as a clear takes priority over the clear.
- R8: The timebase increments by one every clock cycle from reset, and writes to offset 0x8 do not change it.
- R9: When ENABLE_ONCE = 1, the primary enable cannot be cleared by a bus write once it is set. When ENABLE_ONCE = 0, writing 0 to bit 1 clears it.
- R10: Reads of any offset other than 0x0, 0x4 and 0x8 return zero, and writes to them change no state.
- R11: Writing to bit 0 at offset 0x0 does not change the secondary enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address |
| wdog_irq | output | 1 | Interrupt, high while the state bit is set |
| wdog_rst | output | 1 | One-cycle system reset request |

## Verification
The bench goes after the exact cycle on which each stage fires. A counter that is off by one would raise the interrupt or the reset one cycle early or late, and the per-cycle model comparison shows that at once. It also tests restart writes that land on, just before and just after the expiry cycle: a design with the wrong priority would miss the restart or issue a false reset. A design that gates the counter on only one enable, that lets a clear remove the reset-status bit too early, or whose sticky enable could still be cleared, produces read-back values that differ from the model. Writes to the unmapped offset and to the timebase are followed by reads, which show any state those writes corrupted.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

   typedef enum logic [1:0] {
      SEL_CSR0 = 2'd0,
      SEL_CSR1 = 2'd1,
      SEL_TB   = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // Offsets and bit positions that software decodes
   localparam logic [31:0] OFF_CSR0 = 32'h0;
   localparam logic [31:0] OFF_CSR1 = 32'h4;
   localparam logic [31:0] OFF_TB   = 32'h8;

   localparam int BIT_RSTS  = 3;
   localparam int BIT_STATE = 2;
   localparam int BIT_EN1   = 1;
   localparam int BIT_EN2   = 0;

endpackage

// File: rtl/dsw_timebase.sv
module dsw_timebase #(
   parameter int TB_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TB_W-1:0] tb_o
);

   logic [TB_W-1:0] tb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) tb_q <= '0;
      else        tb_q <= tb_q + 1'b1;
   end

   assign tb_o = tb_q;

   AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> tb_q == $past(tb_q) + 1'b1) else $error("timebase step"); // R8

endmodule

// File: rtl/dsw_expiry.sv
module dsw_expiry #(
   parameter int CNT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic running_i,
   input  logic kick_i,
   input  logic clr_rsts_i,
   output logic state_o,
   output logic rsts_o,
   output logic rst_pulse_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             state_q;
   logic             rsts_q;
   logic             pulse_q;
   logic             at_end;
   logic             expire;
   logic             second;

   assign at_end = &cnt_q;
   assign expire = running_i && at_end && !kick_i;
   assign second = expire && state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!running_i || kick_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         rsts_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= second;
         if (kick_i)      state_q <= 1'b0;
         else if (expire) state_q <= 1'b1;
         if (second)          rsts_q <= 1'b1;
         else if (clr_rsts_i) rsts_q <= 1'b0;
      end
   end

   assign state_o     = state_q;
   assign rsts_o      = rsts_q;
   assign rst_pulse_o = pulse_q;

   AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q) else $error("reset pulse longer than one cycle"); // R5
   AST_RST_AFTER_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> state_q && rsts_q) else $error("reset without state"); // R5
   AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      kick_i |=> !state_q && !pulse_q) else $error("restart ignored"); // R6
   AST_EXPIRY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q) |-> $past(running_i)) else $error("expiry while stopped"); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !running_i |=> !$rose(rsts_q) && !pulse_q) else $error("stage while stopped"); // R3

endmodule

// File: rtl/dsw_regs.sv
module dsw_regs
   import dsw_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int TB_W        = 32,
   parameter bit ENABLE_ONCE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [31:0]       wdata_i,
   input  logic              state_i,
   input  logic              rsts_i,
   input  logic [TB_W-1:0]   tb_i,
   output logic [31:0]       rdata_o,
   output logic              running_o,
   output logic              kick_o,
   output logic              clr_rsts_o
);

   reg_sel_e sel;
   logic     en1_q;
   logic     en2_q;
   logic     en1_lock;
   logic     wr0;
   logic     wr1;

   always_comb begin
      if (32'(addr_i) == OFF_CSR0)      sel = SEL_CSR0;
      else if (32'(addr_i) == OFF_CSR1) sel = SEL_CSR1;
      else if (32'(addr_i) == OFF_TB)   sel = SEL_TB;
      else                              sel = SEL_NONE;
   end

   assign wr0 = wr_en_i && (sel == SEL_CSR0);
   assign wr1 = wr_en_i && (sel == SEL_CSR1);

   generate
      if (ENABLE_ONCE) begin : g_lock
         assign en1_lock = en1_q;
         AST_ONCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(en1_q) |-> en1_q) else $error("sticky enable dropped"); // R9
      end else begin : g_free
         assign en1_lock = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en1_q <= 1'b0;
         en2_q <= 1'b0;
      end else begin
         if (wr0) begin
            if (wdata_i[BIT_EN1])  en1_q <= 1'b1;
            else if (!en1_lock)    en1_q <= 1'b0;
         end
         if (wr1) en2_q <= wdata_i[BIT_EN2];
      end
   end

   assign running_o  = en1_q && en2_q;
   assign kick_o     = wr0 && wdata_i[BIT_STATE];
   assign clr_rsts_o = wr0 && wdata_i[BIT_RSTS];

   always_comb begin
      rdata_o = '0;
      unique case (sel)
         SEL_CSR0: begin
            rdata_o[BIT_RSTS]  = rsts_i;
            rdata_o[BIT_STATE] = state_i;
            rdata_o[BIT_EN1]   = en1_q;
            rdata_o[BIT_EN2]   = en2_q;
         end
         SEL_CSR1: rdata_o[BIT_EN2] = en2_q;
         SEL_TB:   rdata_o = 32'(tb_i);
         default:  rdata_o = '0;
      endcase
   end

   AST_EN2_ONLY_CSR1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr1 |=> $stable(en2_q)) else $error("secondary enable moved"); // R11

endmodule

// File: rtl/dsw_top.sv
module dsw_top
   import dsw_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int INTERVAL_LOG2 = 16,
   parameter int TB_W          = 32,
   parameter bit ENABLE_ONCE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              wdog_irq,
   output logic              wdog_rst
);

   generate
      if (INTERVAL_LOG2 < 2 || INTERVAL_LOG2 > 31) begin : g_bad_interval
         $error("INTERVAL_LOG2 must lie in 2..31");
      end
      if (TB_W < 8 || TB_W > 32) begin : g_bad_tb
         $error("TB_W must lie in 8..32");
      end
      if (ADDR_W < 4 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 4..32");
      end
   endgenerate

   logic            running;
   logic            kick;
   logic            clr_rsts;
   logic            state;
   logic            rsts;
   logic            pulse;
   logic [TB_W-1:0] tb;

   dsw_timebase #(.TB_W(TB_W)) u_tb (
      .clk   (clk),
      .rst_n (rst_n),
      .tb_o  (tb)
   );

   dsw_regs #(
      .ADDR_W      (ADDR_W),
      .TB_W        (TB_W),
      .ENABLE_ONCE (ENABLE_ONCE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (reg_addr),
      .wr_en_i    (reg_wr_en),
      .wdata_i    (reg_wdata),
      .state_i    (state),
      .rsts_i     (rsts),
      .tb_i       (tb),
      .rdata_o    (reg_rdata),
      .running_o  (running),
      .kick_o     (kick),
      .clr_rsts_o (clr_rsts)
   );

   dsw_expiry #(.CNT_W(INTERVAL_LOG2)) u_exp (
      .clk         (clk),
      .rst_n       (rst_n),
      .running_i   (running),
      .kick_i      (kick),
      .clr_rsts_i  (clr_rsts),
      .state_o     (state),
      .rsts_o      (rsts),
      .rst_pulse_o (pulse)
   );

   assign wdog_irq = state;
   assign wdog_rst = pulse;

   AST_RST_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |-> wdog_irq) else $error("reset before interrupt"); // R4

endmodule

// File: tb/dsw_top_tb_top.sv
`timescale 1ns/1ps
module dsw_top_tb_top;

   localparam int    N      = 4;
   localparam int    PER    = 1 << N;
   localparam real   HALF   = 10.0;
   localparam int    AW     = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr_en = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   rdata [2];
   logic          irq [2];
   logic          rst [2];

   int checks = 0;
   int fails  = 0;
   bit started = 1'b0;
   bit done = 1'b0;

   always #(HALF) clk = ~clk;

   dsw_top #(.ADDR_W(AW), .INTERVAL_LOG2(N), .ENABLE_ONCE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .reg_rdata(rdata[0]), .wdog_irq(irq[0]), .wdog_rst(rst[0]));

   dsw_top #(.ADDR_W(AW), .INTERVAL_LOG2(N), .ENABLE_ONCE(1'b1)) dut_once_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .reg_rdata(rdata[1]), .wdog_irq(irq[1]), .wdog_rst(rst[1]));

   // Behavioural reference model, one slot per instance
   int          m_cnt [2];
   bit          m_en1 [2];
   bit          m_en2 [2];
   bit          m_state [2];
   bit          m_rsts [2];
   bit          m_pulse [2];
   int unsigned m_tb;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] model_rd(input int i, input logic [AW-1:0] a);
      case (a)
         8'h0:    model_rd = {28'd0, m_rsts[i], m_state[i], m_en1[i], m_en2[i]};
         8'h4:    model_rd = {31'd0, m_en2[i]};
         8'h8:    model_rd = m_tb;
         default: model_rd = 32'd0;
      endcase
   endfunction

   always @(posedge clk) begin
      started <= 1'b1;
      if (!rst_n) begin
         m_tb = 0;
         for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 0; m_en1[i] = 0; m_en2[i] = 0;
            m_state[i] = 0; m_rsts[i] = 0; m_pulse[i] = 0;
         end
      end else begin
         m_tb = m_tb + 1;
         for (int i = 0; i < 2; i++) begin
            bit run, kick, clr, exp_now, second, w0, w1;
            w0 = reg_wr_en && reg_addr == 8'h0;
            w1 = reg_wr_en && reg_addr == 8'h4;
            run = m_en1[i] && m_en2[i];
            kick = w0 && reg_wdata[2];
            clr = w0 && reg_wdata[3];
            exp_now = run && (m_cnt[i] == PER - 1) && !kick;
            second = exp_now && m_state[i];
            m_pulse[i] = second;
            if (second) m_rsts[i] = 1;
            else if (clr) m_rsts[i] = 0;
            if (kick) m_state[i] = 0;
            else if (exp_now) m_state[i] = 1;
            m_cnt[i] = (!run || kick) ? 0 : (m_cnt[i] + 1) % PER;
            if (w0) begin
               if (reg_wdata[1]) m_en1[i] = 1;
               else if (!(i == 1 && m_en1[i])) m_en1[i] = 0;
            end
            if (w1) m_en2[i] = reg_wdata[0];
         end
      end
   end

   // Per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (started && !done) begin
         for (int i = 0; i < 2; i++) begin
            chk(irq[i] == m_state[i], "R4 irq vs model", 32'(irq[i]), 32'(m_state[i]));
            chk(rst[i] == m_pulse[i], "R5 reset vs model", 32'(rst[i]), 32'(m_pulse[i]));
            chk(rdata[i] == model_rd(i, reg_addr), "R2 rdata vs model", rdata[i], model_rd(i, reg_addr));
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk); #1;
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] v0, output logic [31:0] v1);
      @(negedge clk); #1;
      reg_addr = a;
      #1;
      v0 = rdata[0]; v1 = rdata[1];
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(HALF * 2.0 * 200000.0);
      fails++;
      $display("FAIL watchdog expired, run hung");
      finish_run();
   end

   initial begin
      logic [31:0] a0, a1, b0, b1;
      int k;
      bit seen;
      idle(3);
      // R1: reset state
      rd(8'h0, a0, a1);
      chk(a0 == 0 && a1 == 0, "R1 csr0 after reset", a0, 0);
      chk(irq[0] == 0 && rst[0] == 0, "R1 outputs after reset", {irq[0], rst[0]}, 0);
      rst_n = 1'b1;
      idle(2);
      // R8: timebase advances one per clock
      rd(8'h8, a0, a1);
      rd(8'h8, b0, b1);
      chk(b0 == a0 + 1, "R8 timebase step", b0, a0 + 1);
      wr(8'h8, 32'h0);
      rd(8'h8, a0, a1);
      chk(a0 == m_tb, "R8 timebase ignores write", a0, m_tb);
      // R10: unmapped offset
      wr(8'hC, 32'hFFFF_FFFF);
      rd(8'hC, a0, a1);
      chk(a0 == 0 && a1 == 0, "R10 unmapped read", a0, 0);
      rd(8'h0, a0, a1);
      chk(a0 == 0, "R10 unmapped write no effect csr0", a0, 0);
      rd(8'h4, a0, a1);
      chk(a0 == 0, "R10 unmapped write no effect csr1", a0, 0);
      // R11: bit0 of csr0 does not set secondary enable
      wr(8'h0, 32'h3);
      rd(8'h0, a0, a1);
      chk(a0 == 32'h2, "R11 csr0 bit0 read-only", a0, 32'h2);
      // R3: one enable alone does not run
      idle(3 * PER);
      chk(irq[0] == 0, "R3 no expiry with one enable", 32'(irq[0]), 0);
      // R2: secondary enable in csr1, mirrored in csr0
      wr(8'h4, 32'h1);
      rd(8'h4, a0, a1);
      chk(a0 == 1, "R2 csr1 enable readback", a0, 1);
      rd(8'h0, a0, a1);
      chk(a0 == 32'h3, "R2 csr0 shows both enables", a0, 32'h3);
      // R4: first expiry
      idle(PER);
      chk(irq[0] == 1 && rst[0] == 0, "R4 first expiry irq only", {irq[0], rst[0]}, 2'b10);
      rd(8'h0, a0, a1);
      chk(a0 == 32'h7, "R4 state bit set", a0, 32'h7);
      // R6: restart
      wr(8'h0, 32'h6);
      chk(irq[0] == 0, "R6 restart clears irq", 32'(irq[0]), 0);
      // R5: reset arrives 2*PER cycles after restart, one cycle wide
      k = 0; seen = 0;
      while (!seen && k < 4 * PER) begin
         @(negedge clk); k++;
         if (rst[0]) seen = 1;
      end
      chk(seen && k == 2 * PER, "R5 reset timing", k, 2 * PER);
      @(negedge clk);
      chk(rst[0] == 0, "R5 reset single cycle", 32'(rst[0]), 0);
      rd(8'h0, a0, a1);
      chk(a0 == 32'hF, "R5 reset status sticky", a0, 32'hF);
      // R7: zeros clear nothing, then clear reset status only
      wr(8'h0, 32'h2);
      rd(8'h0, a0, a1);
      chk(a0 == 32'hF, "R7 write zero keeps status", a0, 32'hF);
      wr(8'h0, 32'hA);
      rd(8'h0, a0, a1);
      chk(a0 == 32'h7, "R7 clear reset status only", a0, 32'h7);
      // R9: stop; sticky enable survives in once variant
      wr(8'h0, 32'hC);
      wr(8'h4, 32'h0);
      rd(8'h0, a0, a1);
      chk(a0 == 32'h0, "R9 enable cleared when not sticky", a0, 0);
      chk(a1 == 32'h2, "R9 sticky enable kept", a1, 32'h2);
      wr(8'h0, 32'h0);
      rd(8'h0, a0, a1);
      chk(a1 == 32'h2, "R9 sticky enable kept again", a1, 32'h2);
      idle(3 * PER);
      chk(irq[0] == 0 && irq[1] == 0, "R3 stopped stays quiet", {irq[0], irq[1]}, 0);
      // R6/R7: restarts near the expiry cycle, checked by the model
      for (int d = PER - 3; d <= PER + 1; d++) begin
         wr(8'h0, 32'hE);
         wr(8'h4, 32'h1);
         idle(d);
         wr(8'h0, 32'h6);
         idle(PER + d);
         wr(8'h0, 32'hE);
         idle(PER - 1);
         wr(8'h0, 32'h8);
         rd(8'h0, a0, a1);
         chk(a0 == model_rd(0, 8'h0), "R6 restart race readback", a0, model_rd(0, 8'h0));
         wr(8'h0, 32'hC);
         wr(8'h4, 32'h0);
      end
      idle(2);
      finish_run();
   end

endmodule